// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block delivers inter-processor software interrupts among a small cluster of CPUs. A CPU requests one by writing a single dispatch word. The word holds a 4-bit interrupt number, a 2-bit filter and an 8-bit target list. The bus also carries the number of the CPU doing the write. The block keeps one pending bit for each combination of receiving CPU, interrupt number and sending CPU. It reports this state to each receiving CPU through banked byte-lane registers. Those registers can also set or clear the bits directly.

Each receiving CPU has its own acknowledge port. A one-cycle request returns the lowest-numbered pending interrupt together with the number of the CPU that sent it, and clears exactly that one bit. When nothing is pending, the port returns a reserved "none" code. Each acknowledge port runs a two-state machine. `ACK_IDLE` goes to `ACK_REPLY` on a request. `ACK_REPLY` goes back to `ACK_IDLE` when no new request arrives, and stays in `ACK_REPLY` when one does. The response is valid while the port is in `ACK_REPLY`.

Top module: `sgi_dispatch`

## Requirements
- R1: A write with `wr_addr` = 0xF00 is a dispatch. Its fields are: `wr_data[3:0]` interrupt number, `wr_data[23:16]` target list, `wr_data[25:24]` filter. With filter 00, it sets pending bit (target t, interrupt, source = `wr_cpu`) for every t whose list bit t is 1. List bits at or above the CPU count are ignored.
- R2: Filter 01 sets the bit for every CPU except the writer, regardless of the list.
- R3: Filter 10 sets the bit only for the writer, regardless of the list.
- R4: Filter 11 changes no pending state.
- R5: A read at 0xF10+4w or at 0xF20+4w returns the bank of `rd_cpu`. Byte k (bits 8k+7:8k) describes interrupt 4w+k, and bit s of that byte means "pending from source CPU s". Unused bits read 0, and every other address reads 0.
- R6: Writing a 1 to a bit at 0xF20+4w sets that bit in the writer's bank. Writing a 1 to a bit at 0xF10+4w clears it. Data bits that are 0 leave state unchanged.
- R7: `irq_pend[c]` is 1 exactly when any bit in bank c is set.
- R8: If `ack_req[c]` is sampled high at a clock edge, then after that edge `ack_valid[c]` is 1 for one cycle. `ack_data` then holds the lowest pending interrupt number in [9:0] and the lowest pending source for that number in [12:10]. All other bits are 0.
- R9: An acknowledge clears only the reported (interrupt, source) bit. Other sources of the same interrupt stay pending.
- R10: An acknowledge with an empty bank returns 1023 in [9:0] and source 0, and changes no state.
- R11: After reset, all pending bits, `irq_pend` and `ack_valid` are 0.
- R12: If one edge both clears a bit (by acknowledge or register) and sets the same bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | 2 | Number of the writing CPU |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_cpu | input | 2 | Bank selected for reads |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| ack_req | input | 4 | Acknowledge request, one bit per CPU |
| ack_valid | output | 4 | Acknowledge response valid, one bit per CPU |
| ack_data | output | 128 | Acknowledge response, 32 bits per CPU |
| irq_pend | output | 4 | Any software interrupt pending, per CPU |

## Verification
The bench targets the following corner cases:

- **Target list wider than the cluster.** The list carries bits above the CPU count. A design that wrapped or used those bits would raise pending state on the wrong CPU.
- **Filter 01 and the writer's own bank.** A design that ignored the writer under this filter would flag its own bank.
- **Reserved filter 11.** A design that treated it as a list dispatch would create pending state.
- **Two sources on one interrupt.** A design that cleared the whole byte on acknowledge would lose the second request.
- **Empty acknowledge.** A design that returned stale data would report a real interrupt.
- **Acknowledge and re-dispatch on the same edge.** A design that gave the clear priority would drop the new request.

Throughout the run, a behavioural model compares `irq_pend` and the acknowledge responses on every cycle.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int ADDR_W = 12;
    localparam int ACK_ID_W = 10;
    localparam int ACK_SRC_W = 3;
    localparam int NONE_ID = 1023;
    localparam logic [ADDR_W-1:0] OFS_DISPATCH = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_CLR_BASE = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_SET_BASE = 12'hF20;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'b00,
        FLT_OTHERS = 2'b01,
        FLT_SELF   = 2'b10,
        FLT_RSVD   = 2'b11
    } flt_e;

    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_REPLY = 1'b1
    } ack_st_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int SRC_W = 2
) (
    input  flt_e               flt,
    input  logic [7:0]         list,
    input  logic [SRC_W-1:0]   writer,
    output logic [NUM_CPU-1:0] targets
);
    logic [NUM_CPU-1:0] self_mask;

    always_comb begin
        self_mask = '0;
        self_mask[writer] = 1'b1;
        unique case (flt)
            FLT_LIST:   targets = list[NUM_CPU-1:0];
            FLT_OTHERS: targets = ~self_mask;
            FLT_SELF:   targets = self_mask;
            default:    targets = '0;
        endcase
    end
endmodule

// File: rtl/sgi_ack_port.sv
module sgi_ack_port
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_ID = 16,
    parameter int SRC_W = 2,
    parameter int ID_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req,
    input  logic [NUM_ID*NUM_CPU-1:0] pend_flat,
    output logic [NUM_ID*NUM_CPU-1:0] clr_flat,
    output logic                      ack_valid,
    output logic [31:0]               ack_data
);
    ack_st_e state_q, state_d;
    logic [31:0] data_q, data_d;
    logic [ID_W-1:0] pick_id;
    logic [SRC_W-1:0] pick_src;
    logic found;

    // lowest interrupt number first, then lowest source within it
    always_comb begin
        found = 1'b0;
        pick_id = '0;
        pick_src = '0;
        for (int i = NUM_ID - 1; i >= 0; i--) begin
            if (|pend_flat[i*NUM_CPU +: NUM_CPU]) begin
                found = 1'b1;
                pick_id = ID_W'(i);
            end
        end
        for (int s = NUM_CPU - 1; s >= 0; s--) begin
            if (pend_flat[int'(pick_id)*NUM_CPU + s]) pick_src = SRC_W'(s);
        end
        clr_flat = '0;
        if (ack_req && found) clr_flat[int'(pick_id)*NUM_CPU + int'(pick_src)] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        data_d = data_q;
        unique case (state_q)
            ACK_IDLE:  state_d = ack_req ? ACK_REPLY : ACK_IDLE;
            ACK_REPLY: state_d = ack_req ? ACK_REPLY : ACK_IDLE;
        endcase
        if (ack_req) begin
            data_d = '0;
            if (found) begin
                data_d[ACK_ID_W-1:0] = ACK_ID_W'(pick_id);
                data_d[ACK_ID_W +: ACK_SRC_W] = ACK_SRC_W'(pick_src);
            end else begin
                data_d[ACK_ID_W-1:0] = ACK_ID_W'(NONE_ID);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            data_q <= '0;
        end else begin
            state_q <= state_d;
            data_q <= data_d;
        end
    end

    always_comb begin
        ack_valid = (state_q == ACK_REPLY);
        ack_data = data_q;
    end

    assert_reply_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_REPLY) |-> $past(ack_req));

    assert_none_only_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_data[ACK_ID_W-1:0] == ACK_ID_W'(NONE_ID)) |-> ($past(pend_flat) == '0));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_ID = 16,
    localparam int SRC_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W = $clog2(NUM_ID),
    localparam int WORDS = NUM_ID / 4,
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SRC_W-1:0]      wr_cpu,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [SRC_W-1:0]      rd_cpu,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [31:0]           rd_data,
    input  logic [NUM_CPU-1:0]    ack_req,
    output logic [NUM_CPU-1:0]    ack_valid,
    output logic [NUM_CPU*32-1:0] ack_data,
    output logic [NUM_CPU-1:0]    irq_pend
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(4 * WORDS);

    logic [NUM_CPU-1:0][NUM_ID-1:0][NUM_CPU-1:0] pend_q, pend_d;
    logic [NUM_CPU-1:0][NUM_ID*NUM_CPU-1:0] ack_clr;
    logic [NUM_CPU-1:0] targets;
    logic [ADDR_W-1:0] set_off, clr_off, rset_off, rclr_off;
    logic disp_hit, set_hit, clr_hit, rd_hit;
    logic [WORD_W-1:0] set_word, clr_word, rd_word;
    logic [ID_W-1:0] wr_id;

    always_comb begin
        disp_hit = wr_en && (wr_addr == OFS_DISPATCH);
        wr_id = wr_data[ID_W-1:0];
        set_off = wr_addr - OFS_SET_BASE;
        clr_off = wr_addr - OFS_CLR_BASE;
        set_hit = wr_en && (wr_addr >= OFS_SET_BASE) && (set_off < WIN) && (wr_addr[1:0] == 2'b00);
        clr_hit = wr_en && (wr_addr >= OFS_CLR_BASE) && (clr_off < WIN) && (wr_addr[1:0] == 2'b00);
        set_word = set_off[WORD_W+1:2];
        clr_word = clr_off[WORD_W+1:2];
        rset_off = rd_addr - OFS_SET_BASE;
        rclr_off = rd_addr - OFS_CLR_BASE;
        rd_hit = 1'b0;
        rd_word = '0;
        if (rd_addr[1:0] == 2'b00) begin
            if ((rd_addr >= OFS_SET_BASE) && (rset_off < WIN)) begin
                rd_hit = 1'b1;
                rd_word = rset_off[WORD_W+1:2];
            end else if ((rd_addr >= OFS_CLR_BASE) && (rclr_off < WIN)) begin
                rd_hit = 1'b1;
                rd_word = rclr_off[WORD_W+1:2];
            end
        end
    end

    sgi_target_decode #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W)) u_decode (
        .flt     (flt_e'(wr_data[25:24])),
        .list    (wr_data[23:16]),
        .writer  (wr_cpu),
        .targets (targets)
    );

    // clear terms first, set terms last: a same-edge set wins
    always_comb begin
        pend_d = pend_q;
        for (int t = 0; t < NUM_CPU; t++) begin
            for (int i = 0; i < NUM_ID; i++) begin
                for (int s = 0; s < NUM_CPU; s++) begin
                    pend_d[t][i][s] =
                        (pend_q[t][i][s] & ~(ack_clr[t][i*NUM_CPU+s] |
                            (clr_hit && wr_cpu == SRC_W'(t) && clr_word == WORD_W'(i/4) && wr_data[8*(i%4)+s])))
                        | (disp_hit && targets[t] && wr_id == ID_W'(i) && wr_cpu == SRC_W'(s))
                        | (set_hit && wr_cpu == SRC_W'(t) && set_word == WORD_W'(i/4) && wr_data[8*(i%4)+s]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= pend_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            for (int k = 0; k < 4; k++) begin
                for (int s = 0; s < NUM_CPU; s++) begin
                    if (int'(rd_word) * 4 + k < NUM_ID)
                        rd_data[8*k+s] = pend_q[rd_cpu][int'(rd_word)*4+k][s];
                end
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
        assign irq_pend[c] = |pend_q[c];

        sgi_ack_port #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID), .SRC_W(SRC_W), .ID_W(ID_W)) u_ack (
            .clk       (clk),
            .rst_n     (rst_n),
            .ack_req   (ack_req[c]),
            .pend_flat (pend_q[c]),
            .clr_flat  (ack_clr[c]),
            .ack_valid (ack_valid[c]),
            .ack_data  (ack_data[c*32 +: 32])
        );

        assert_self_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_hit && wr_data[25:24] == 2'b10 && wr_cpu == SRC_W'(c))
            |=> pend_q[c][$past(wr_id)][c]);

        assert_writer_skipped_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_hit && wr_data[25:24] == 2'b01 && wr_cpu == SRC_W'(c) && !ack_req[c])
            |=> (pend_q[c][$past(wr_id)][c] == $past(pend_q[c][wr_id][c])));
    end

    assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_hit && wr_data[25:24] == 2'b11 && ack_req == '0) |=> (pend_q == $past(pend_q)));
endmodule

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_cpu = '0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0] rd_cpu = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0] ack_req = '0;
    logic [3:0] ack_valid;
    logic [127:0] ack_data;
    logic [3:0] irq_pend;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_data(ack_data), .irq_pend(irq_pend)
    );

    // behavioural reference: pending[target][id][source]
    bit mp [4][16][4];
    bit ev [4];
    int ed [4];

    function automatic bit bank_any(int t);
        for (int i = 0; i < 16; i++)
            for (int s = 0; s < 4; s++)
                if (mp[t][i][s]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 4; t++) begin
                ev[t] = 0;
                for (int i = 0; i < 16; i++)
                    for (int s = 0; s < 4; s++) mp[t][i][s] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                ev[c] = ack_req[c];
                if (ack_req[c]) begin
                    ed[c] = 1023;
                    for (int i = 15; i >= 0; i--)
                        for (int s = 3; s >= 0; s--)
                            if (mp[c][i][s]) ed[c] = (s << 10) | i;
                    if (ed[c] != 1023) mp[c][ed[c] & 15][ed[c] >> 10] = 0;
                end
            end
            if (wr_en) begin
                if (wr_addr == 12'hF00) begin
                    for (int t = 0; t < 4; t++) begin
                        bit hit;
                        case (wr_data[25:24])
                            2'b00: hit = wr_data[16+t];
                            2'b01: hit = (t != int'(wr_cpu));
                            2'b10: hit = (t == int'(wr_cpu));
                            default: hit = 0;
                        endcase
                        if (hit) mp[t][wr_data[3:0]][wr_cpu] = 1;
                    end
                end else if (wr_addr[1:0] == 0 && wr_addr >= 12'hF10 && wr_addr < 12'hF30) begin
                    int w;
                    w = (wr_addr < 12'hF20) ? (int'(wr_addr) - 'hF10) / 4 : (int'(wr_addr) - 'hF20) / 4;
                    for (int k = 0; k < 4; k++)
                        for (int s = 0; s < 4; s++)
                            if (wr_data[8*k+s]) mp[wr_cpu][4*w+k][s] = (wr_addr >= 12'hF20);
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 4; c++) begin
                check("R7 irq_pend vs model", 32'(irq_pend[c]), 32'(bank_any(c)));
                check("R8 ack_valid vs model", 32'(ack_valid[c]), 32'(ev[c]));
                if (ev[c]) check("R8 ack_data vs model", ack_data[c*32 +: 32], 32'(ed[c]));
            end
        end
    end

    task automatic wr(input logic [1:0] cpu, input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_cpu = cpu; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic disp(input logic [1:0] cpu, input logic [1:0] flt, input logic [7:0] list, input logic [3:0] id);
        wr(cpu, 12'hF00, {6'b0, flt, list, 12'b0, id});
    endtask

    task automatic rd_chk(input logic [1:0] cpu, input logic [11:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_cpu = cpu; rd_addr = addr;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic ack_chk(input int c, input logic [31:0] exp, input string tag);
        @(negedge clk);
        ack_req[c] = 1'b1;
        @(negedge clk);
        ack_req[c] = 1'b0;
        check(tag, {31'b0, ack_valid[c]}, 32'd1);
        check(tag, ack_data[c*32 +: 32], exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        check("R11 irq_pend after reset", {28'b0, irq_pend}, 32'h0);
        check("R11 ack_valid after reset", {28'b0, ack_valid}, 32'h0);
        rst_n = 1'b1;
        rd_chk(2'd0, 12'hF20, 32'h0, "R11 bank empty after reset");

        // R1 list filter, high list bits ignored: targets 0,2,3
        disp(2'd1, 2'b00, 8'h8D, 4'd5);
        rd_chk(2'd0, 12'hF24, 32'h0000_0200, "R1 cpu0 id5 from src1");
        rd_chk(2'd1, 12'hF24, 32'h0, "R1 cpu1 not targeted");
        rd_chk(2'd2, 12'hF14, 32'h0000_0200, "R5 clear window reads pending");
        check("R7 irq_pend after list dispatch", {28'b0, irq_pend}, 32'hD);

        // R2 all except writer
        disp(2'd2, 2'b01, 8'h00, 4'd0);
        rd_chk(2'd2, 12'hF20, 32'h0, "R2 writer skipped");
        rd_chk(2'd1, 12'hF20, 32'h04, "R2 cpu1 id0 from src2");
        rd_chk(2'd3, 12'hF20, 32'h04, "R2 cpu3 id0 from src2");

        // R3 writer only
        disp(2'd3, 2'b10, 8'hFF, 4'd15);
        rd_chk(2'd3, 12'hF2C, 32'h0800_0000, "R3 self id15");
        rd_chk(2'd0, 12'hF2C, 32'h0, "R3 other cpu untouched");

        // R4 reserved filter
        disp(2'd0, 2'b11, 8'hFF, 4'd7);
        rd_chk(2'd0, 12'hF24, 32'h0000_0200, "R4 cpu0 bank unchanged");
        rd_chk(2'd1, 12'hF24, 32'h0, "R4 cpu1 bank unchanged");
        check("R4 irq_pend unchanged", {28'b0, irq_pend}, 32'hF);

        // R5 unmapped reads
        rd_chk(2'd0, 12'hF30, 32'h0, "R5 past window");
        rd_chk(2'd0, 12'hF00, 32'h0, "R5 dispatch reads zero");

        // R8 / R10 acknowledge order and empty
        ack_chk(0, 32'h0000_0800, "R8 lowest id first");
        ack_chk(0, 32'h0000_0405, "R8 next id with source");
        ack_chk(0, 32'h0000_03FF, "R10 empty returns none");
        check("R7 cpu0 idle after acks", {31'b0, irq_pend[0]}, 32'h0);
        rd_chk(2'd0, 12'hF24, 32'h0, "R10 bank still empty");

        // R9 two sources on one id
        wr(2'd1, 12'hF24, 32'h0000_0300);
        ack_chk(1, 32'h0000_0800, "R9 id0 src2 first");
        ack_chk(1, 32'h0000_0005, "R9 id5 lowest source");
        rd_chk(2'd1, 12'hF24, 32'h0000_0200, "R9 other source kept");
        check("R9 irq still pending", {31'b0, irq_pend[1]}, 32'h1);

        // R6 clear by register, zero bits inert
        wr(2'd1, 12'hF14, 32'h0000_0200);
        rd_chk(2'd1, 12'hF24, 32'h0, "R6 cleared by write-one");
        check("R6 irq drops", {31'b0, irq_pend[1]}, 32'h0);
        wr(2'd3, 12'hF1C, 32'h0);
        rd_chk(2'd3, 12'hF2C, 32'h0800_0000, "R6 zero write inert");

        // R12 acknowledge and re-dispatch of the same bit on one edge
        @(negedge clk);
        ack_req[3] = 1'b1;
        wr_en = 1'b1; wr_cpu = 2'd2; wr_addr = 12'hF00; wr_data = {6'b0, 2'b00, 8'h08, 12'b0, 4'd0};
        @(negedge clk);
        ack_req[3] = 1'b0; wr_en = 1'b0;
        check("R12 ack reports id0 src2", ack_data[96 +: 32], 32'h0000_0800);
        rd_chk(2'd3, 12'hF20, 32'h04, "R12 set wins over clear");

        // mixed traffic checked by the per-cycle model
        seed = 7;
        for (int n = 0; n < 300; n++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            @(negedge clk);
            ack_req = 4'(seed >> 20) & 4'(seed >> 8);
            wr_en = seed[3];
            wr_cpu = 2'(seed >> 5);
            wr_addr = seed[4] ? 12'hF00 : (seed[9] ? 12'hF10 : 12'hF20) + 12'((seed >> 12) & 'hC);
            wr_data = {6'b0, 2'(seed >> 14), 8'(seed >> 16), 8'(seed >> 2), 4'(seed >> 24), 4'(seed >> 26)};
        end
        @(negedge clk);
        ack_req = '0; wr_en = 1'b0;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule